// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block caches page-table entries so that a virtual page number can be turned into a physical page number in the same cycle as the request. Each of its 64 slots holds a virtual page tag, the identifier of the owning process, the physical page number, a present flag, two protection bits, a referenced flag and a dirty flag. A lookup compares the virtual page and the process identifier against every slot at once. Because the process identifier is part of the match, entries of several processes can live side by side and a context switch needs no flush.

The result of a lookup falls into exactly one of four classes. A translation miss means no slot matched, so a page-table walk is needed. A page fault means a slot matched but its page is not resident. A protection fault means a write hit a page that forbids writes. A hit returns the translation. A hit marks the slot as referenced, and a write hit also marks the page dirty. After a walk, the fill port installs a new entry in a slot chosen from the valid and referenced flags. Flush-all and flush-by-process controls remove stale entries.

The control path is a two-state machine. `ST_INIT` is entered on reset. During it the block reports no lookup result and ignores fills. On the first clock edge after reset is released, the machine takes the transition `INIT_TO_READY` and moves to `ST_READY`. The transition `READY_HOLD` keeps it in `ST_READY` until the next reset.

Top module: `asid_tlb`

## Requirements
- R1: In `ST_READY`, a lookup whose page number and process identifier both match a valid slot that is present and permits the access raises `lk_hit` in the same cycle. It also returns that slot's `lk_ppn`, `lk_prot` and `lk_slot`.
- R2: A slot whose page number matches but whose process identifier differs does not match. The lookup reports `lk_miss`.
- R3: The four result flags `lk_hit`, `lk_miss`, `lk_page_fault` and `lk_prot_fault` are mutually exclusive. A lookup with no matching slot raises `lk_miss`. A matching slot whose present flag is 0 raises `lk_page_fault` and reports its slot.
- R4: A write hit sets the slot's dirty flag from the next cycle on. `lk_dirty` shows the flag as it stood before the current lookup.
- R5: A write to a matching, present slot whose protection bit 0 (write allowed) is 0 raises `lk_prot_fault` instead of `lk_hit`, and the dirty flag stays unchanged.
- R6: A fill that is accepted writes the lowest-numbered invalid slot, if there is one. The new entry has its dirty and referenced flags cleared.
- R7: Every hit sets the slot's referenced flag. When all slots are valid, a fill replaces the lowest-numbered slot whose referenced flag is 0.
- R8: When all slots are valid and all referenced flags are 1, a fill replaces slot 0 and clears every referenced flag. A hit in that same cycle still sets its own slot's flag.
- R9: `flush_all` invalidates every slot at the next clock edge.
- R10: `flush_asid_req` invalidates exactly the valid slots whose process identifier equals `flush_asid`. Other slots keep hitting.
- R11: After reset is released, `ready` stays 0 for one cycle (`ST_INIT`). During that cycle a lookup raises no result flag. `ready` is 1 from the following cycle on.
- R12: A fill requested in the same cycle as either flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is for a write access |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_asid | input | 8 | Identifier of the current process |
| lk_hit | output | 1 | Translation valid and access permitted |
| lk_miss | output | 1 | No slot matched |
| lk_page_fault | output | 1 | Matching slot is not present |
| lk_prot_fault | output | 1 | Write to a write-protected page |
| lk_ppn | output | 16 | Physical page number of the matching slot |
| lk_prot | output | 2 | Protection bits of the matching slot (bit 0 = write allowed) |
| lk_dirty | output | 1 | Dirty flag of the matching slot before this lookup |
| lk_slot | output | 6 | Index of the matching slot |
| fill_req | input | 1 | Install a new entry |
| fill_vpn | input | 20 | Virtual page number of the new entry |
| fill_asid | input | 8 | Process identifier of the new entry |
| fill_ppn | input | 16 | Physical page number of the new entry |
| fill_present | input | 1 | Present flag of the new entry |
| fill_prot | input | 2 | Protection bits of the new entry |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid_req | input | 1 | Invalidate the slots of one process |
| flush_asid | input | 8 | Process identifier to flush |
| ready | output | 1 | Machine is in `ST_READY` |

## Verification
Lookup results are combinational. They are due in the same cycle the request is driven, so the bench drives each request just after a rising edge and its monitor compares the flags, slot, page number and dirty flag at the following falling edge. Fills, flushes and the referenced and dirty updates take effect at the next rising edge. Their checks are therefore lookups issued in a later cycle that observe the changed slot contents through the same ports. The one-cycle `ST_INIT` window after reset is checked by sampling `ready` and a lookup in that cycle and again one edge later.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

    typedef enum logic [0:0] {
        ST_INIT  = 1'b0,
        ST_READY = 1'b1
    } tlb_state_e;

    localparam int unsigned PROT_WR_BIT = 0;

endpackage

// File: rtl/asid_tlb_match.sv
module asid_tlb_match #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned ASID_W  = 8,
    parameter int unsigned PPN_W   = 16,
    parameter int unsigned PROT_W  = 2,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [VPN_W-1:0]                 q_vpn,
    input  logic [ASID_W-1:0]                q_asid,
    input  logic [ENTRIES-1:0]               valid_v,
    input  logic [ENTRIES-1:0][VPN_W-1:0]    vpn_v,
    input  logic [ENTRIES-1:0][ASID_W-1:0]   asid_v,
    input  logic [ENTRIES-1:0][PPN_W-1:0]    ppn_v,
    input  logic [ENTRIES-1:0]               present_v,
    input  logic [ENTRIES-1:0][PROT_W-1:0]   prot_v,
    input  logic [ENTRIES-1:0]               dirty_v,
    output logic                             match_any,
    output logic [IDX_W-1:0]                 match_idx,
    output logic [PPN_W-1:0]                 sel_ppn,
    output logic [PROT_W-1:0]                sel_prot,
    output logic                             sel_present,
    output logic                             sel_dirty
);

    logic [ENTRIES-1:0] hit_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = valid_v[g] && (vpn_v[g] == q_vpn) && (asid_v[g] == q_asid);
    end

    always_comb begin
        match_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                match_idx = IDX_W'(i);
            end
        end
    end

    assign match_any   = |hit_vec;
    assign sel_ppn     = ppn_v[match_idx];
    assign sel_prot    = prot_v[match_idx];
    assign sel_present = present_v[match_idx];
    assign sel_dirty   = dirty_v[match_idx];

endmodule

// File: rtl/asid_tlb_victim.sv
module asid_tlb_victim #(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_v,
    input  logic [ENTRIES-1:0] ref_v,
    output logic [IDX_W-1:0]   victim_idx,
    output logic               clr_refs
);

    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] cold_idx;
    logic             have_free;
    logic             have_cold;

    always_comb begin
        free_idx = '0;
        cold_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_v[i]) begin
                free_idx = IDX_W'(i);
            end
            if (!ref_v[i]) begin
                cold_idx = IDX_W'(i);
            end
        end
    end

    assign have_free = ~&valid_v;
    assign have_cold = ~&ref_v;

    always_comb begin
        if (have_free) begin
            victim_idx = free_idx;
            clr_refs   = 1'b0;
        end else if (have_cold) begin
            victim_idx = cold_idx;
            clr_refs   = 1'b0;
        end else begin
            victim_idx = '0;
            clr_refs   = 1'b1;
        end
    end

endmodule

// File: rtl/asid_tlb_ctrl.sv
module asid_tlb_ctrl
    import asid_tlb_pkg::*;
#(
    parameter int unsigned PROT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic              lk_write,
    input  logic              match_any,
    input  logic              sel_present,
    input  logic [PROT_W-1:0] sel_prot,
    input  logic              fill_req,
    input  logic              flush_all,
    input  logic              flush_asid_req,
    output logic              ready,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_pf,
    output logic              res_prot,
    output logic              upd_ref,
    output logic              set_dirty,
    output logic              fill_en
);

    tlb_state_e st_q;
    tlb_state_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_INIT:  st_d = ST_READY;   // INIT_TO_READY
            ST_READY: st_d = ST_READY;   // READY_HOLD
            default:  st_d = ST_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    logic wr_ok;
    assign wr_ok = sel_prot[PROT_WR_BIT];

    always_comb begin
        ready     = 1'b0;
        res_hit   = 1'b0;
        res_miss  = 1'b0;
        res_pf    = 1'b0;
        res_prot  = 1'b0;
        fill_en   = 1'b0;
        unique case (st_q)
            ST_INIT: begin
                ready = 1'b0;
            end
            ST_READY: begin
                ready   = 1'b1;
                fill_en = fill_req && !flush_all && !flush_asid_req;
                if (lk_req) begin
                    if (!match_any) begin
                        res_miss = 1'b1;
                    end else if (!sel_present) begin
                        res_pf = 1'b1;
                    end else if (lk_write && !wr_ok) begin
                        res_prot = 1'b1;
                    end else begin
                        res_hit = 1'b1;
                    end
                end
            end
            default: ready = 1'b0;
        endcase
    end

    assign upd_ref   = res_hit;
    assign set_dirty = res_hit && lk_write;

    // R3: one result class per lookup
    p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_hit, res_miss, res_pf, res_prot}));

    // R3: a ready lookup always yields a class
    p_lookup_classified_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && lk_req) |-> (res_hit || res_miss || res_pf || res_prot));

    // R11: nothing reported or installed outside the ready state
    p_quiet_init_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !(res_hit || res_miss || res_pf || res_prot || fill_en));

    // R12: flushes drop a simultaneous fill
    p_flush_beats_fill_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all || flush_asid_req) |-> !fill_en);

endmodule

// File: rtl/asid_tlb_store.sv
module asid_tlb_store #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned ASID_W  = 8,
    parameter int unsigned PPN_W   = 16,
    parameter int unsigned PROT_W  = 2,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush_all,
    input  logic                             flush_asid_req,
    input  logic [ASID_W-1:0]                flush_asid,
    input  logic                             fill_en,
    input  logic [IDX_W-1:0]                 victim_idx,
    input  logic                             clr_refs,
    input  logic [VPN_W-1:0]                 fill_vpn,
    input  logic [ASID_W-1:0]                fill_asid,
    input  logic [PPN_W-1:0]                 fill_ppn,
    input  logic                             fill_present,
    input  logic [PROT_W-1:0]                fill_prot,
    input  logic                             upd_ref,
    input  logic                             set_dirty,
    input  logic                             prot_fault,
    input  logic [IDX_W-1:0]                 hit_idx,
    output logic [ENTRIES-1:0]               valid_q,
    output logic [ENTRIES-1:0][VPN_W-1:0]    vpn_q,
    output logic [ENTRIES-1:0][ASID_W-1:0]   asid_q,
    output logic [ENTRIES-1:0][PPN_W-1:0]    ppn_q,
    output logic [ENTRIES-1:0]               present_q,
    output logic [ENTRIES-1:0][PROT_W-1:0]   prot_q,
    output logic [ENTRIES-1:0]               ref_q,
    output logic [ENTRIES-1:0]               dirty_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q   <= '0;
            vpn_q     <= '0;
            asid_q    <= '0;
            ppn_q     <= '0;
            present_q <= '0;
            prot_q    <= '0;
            ref_q     <= '0;
            dirty_q   <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush_all) begin
                    valid_q[i] <= 1'b0;
                end else if (flush_asid_req && valid_q[i] && (asid_q[i] == flush_asid)) begin
                    valid_q[i] <= 1'b0;
                end else if (fill_en && (victim_idx == IDX_W'(i))) begin
                    valid_q[i]   <= 1'b1;
                    vpn_q[i]     <= fill_vpn;
                    asid_q[i]    <= fill_asid;
                    ppn_q[i]     <= fill_ppn;
                    present_q[i] <= fill_present;
                    prot_q[i]    <= fill_prot;
                    ref_q[i]     <= 1'b0;
                    dirty_q[i]   <= 1'b0;
                end else begin
                    if (fill_en && clr_refs) begin
                        ref_q[i] <= 1'b0;
                    end
                    if (upd_ref && (hit_idx == IDX_W'(i))) begin
                        ref_q[i] <= 1'b1;
                    end
                    if (set_dirty && (hit_idx == IDX_W'(i))) begin
                        dirty_q[i] <= 1'b1;
                    end
                end
            end
        end
    end

    // R9: flush-all empties the buffer at the next edge
    p_flush_all_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0));

    // R4: a write hit leaves the slot dirty unless the slot is refilled
    p_write_hit_dirty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_dirty && !(fill_en && (victim_idx == hit_idx))) |=> dirty_q[$past(hit_idx)]);

    // R5: a protection fault leaves the dirty flags alone
    p_prot_keeps_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_fault && !fill_en) |=> (dirty_q == $past(dirty_q)));

    // R6: an accepted fill leaves a valid, clean slot behind
    p_fill_installs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (valid_q[$past(victim_idx)] && !dirty_q[$past(victim_idx)]));

    // R7: a hit marks its slot as referenced
    p_hit_refs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_ref && !(fill_en && (victim_idx == hit_idx))) |=> ref_q[$past(hit_idx)]);

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned ASID_W  = 8,
    parameter int unsigned PPN_W   = 16,
    parameter int unsigned PROT_W  = 2,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic              lk_write,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_page_fault,
    output logic              lk_prot_fault,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [PROT_W-1:0] lk_prot,
    output logic              lk_dirty,
    output logic [IDX_W-1:0]  lk_slot,
    input  logic              fill_req,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              fill_present,
    input  logic [PROT_W-1:0] fill_prot,
    input  logic              flush_all,
    input  logic              flush_asid_req,
    input  logic [ASID_W-1:0] flush_asid,
    output logic              ready
);

    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
    logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
    logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
    logic [ENTRIES-1:0]             present_q;
    logic [ENTRIES-1:0][PROT_W-1:0] prot_q;
    logic [ENTRIES-1:0]             ref_q;
    logic [ENTRIES-1:0]             dirty_q;

    logic              match_any;
    logic [IDX_W-1:0]  match_idx;
    logic [PPN_W-1:0]  sel_ppn;
    logic [PROT_W-1:0] sel_prot;
    logic              sel_present;
    logic              sel_dirty;
    logic [IDX_W-1:0]  victim_idx;
    logic              clr_refs;
    logic              res_hit;
    logic              res_miss;
    logic              res_pf;
    logic              res_prot;
    logic              upd_ref;
    logic              set_dirty;
    logic              fill_en;

    asid_tlb_match #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
        .PPN_W(PPN_W), .PROT_W(PROT_W)
    ) u_match (
        .q_vpn       (lk_vpn),
        .q_asid      (lk_asid),
        .valid_v     (valid_q),
        .vpn_v       (vpn_q),
        .asid_v      (asid_q),
        .ppn_v       (ppn_q),
        .present_v   (present_q),
        .prot_v      (prot_q),
        .dirty_v     (dirty_q),
        .match_any   (match_any),
        .match_idx   (match_idx),
        .sel_ppn     (sel_ppn),
        .sel_prot    (sel_prot),
        .sel_present (sel_present),
        .sel_dirty   (sel_dirty)
    );

    asid_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid_v    (valid_q),
        .ref_v      (ref_q),
        .victim_idx (victim_idx),
        .clr_refs   (clr_refs)
    );

    asid_tlb_ctrl #(.PROT_W(PROT_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .lk_req         (lk_req),
        .lk_write       (lk_write),
        .match_any      (match_any),
        .sel_present    (sel_present),
        .sel_prot       (sel_prot),
        .fill_req       (fill_req),
        .flush_all      (flush_all),
        .flush_asid_req (flush_asid_req),
        .ready          (ready),
        .res_hit        (res_hit),
        .res_miss       (res_miss),
        .res_pf         (res_pf),
        .res_prot       (res_prot),
        .upd_ref        (upd_ref),
        .set_dirty      (set_dirty),
        .fill_en        (fill_en)
    );

    asid_tlb_store #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
        .PPN_W(PPN_W), .PROT_W(PROT_W)
    ) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush_all      (flush_all),
        .flush_asid_req (flush_asid_req),
        .flush_asid     (flush_asid),
        .fill_en        (fill_en),
        .victim_idx     (victim_idx),
        .clr_refs       (clr_refs),
        .fill_vpn       (fill_vpn),
        .fill_asid      (fill_asid),
        .fill_ppn       (fill_ppn),
        .fill_present   (fill_present),
        .fill_prot      (fill_prot),
        .upd_ref        (upd_ref),
        .set_dirty      (set_dirty),
        .prot_fault     (res_prot),
        .hit_idx        (match_idx),
        .valid_q        (valid_q),
        .vpn_q          (vpn_q),
        .asid_q         (asid_q),
        .ppn_q          (ppn_q),
        .present_q      (present_q),
        .prot_q         (prot_q),
        .ref_q          (ref_q),
        .dirty_q        (dirty_q)
    );

    logic show_entry;
    assign show_entry = res_hit || res_pf || res_prot;

    assign lk_hit        = res_hit;
    assign lk_miss       = res_miss;
    assign lk_page_fault = res_pf;
    assign lk_prot_fault = res_prot;
    assign lk_ppn        = show_entry ? sel_ppn   : '0;
    assign lk_prot       = show_entry ? sel_prot  : '0;
    assign lk_dirty      = show_entry ? sel_dirty : 1'b0;
    assign lk_slot       = show_entry ? match_idx : '0;

    // R1: a hit always carries a present translation
    p_hit_present_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (match_any && sel_present));

endmodule

// File: tb/asid_tlb_tb_top.sv
`timescale 1ns/1ps
module asid_tlb_tb_top;

    localparam int ENTRIES = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic        lk_write = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit, lk_miss, lk_page_fault, lk_prot_fault;
    logic [15:0] lk_ppn;
    logic [1:0]  lk_prot;
    logic        lk_dirty;
    logic [5:0]  lk_slot;
    logic        fill_req = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [15:0] fill_ppn = '0;
    logic        fill_present = 1'b0;
    logic [1:0]  fill_prot = '0;
    logic        flush_all = 1'b0;
    logic        flush_asid_req = 1'b0;
    logic [7:0]  flush_asid = '0;
    logic        ready;

    always #2.5 clk = ~clk;

    asid_tlb dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_write(lk_write), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_page_fault(lk_page_fault),
        .lk_prot_fault(lk_prot_fault), .lk_ppn(lk_ppn), .lk_prot(lk_prot),
        .lk_dirty(lk_dirty), .lk_slot(lk_slot),
        .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_ppn(fill_ppn), .fill_present(fill_present), .fill_prot(fill_prot),
        .flush_all(flush_all), .flush_asid_req(flush_asid_req),
        .flush_asid(flush_asid), .ready(ready)
    );

    // expected class bits: {hit, miss, page_fault, prot_fault}
    localparam logic [3:0] K_HIT  = 4'b1000;
    localparam logic [3:0] K_MISS = 4'b0100;
    localparam logic [3:0] K_PF   = 4'b0010;
    localparam logic [3:0] K_PROT = 4'b0001;
    localparam logic [3:0] K_NONE = 4'b0000;

    typedef struct {
        logic [3:0]  kind;
        logic [15:0] ppn;
        logic [5:0]  slot;
        logic        dirty;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic note_fail(string tag, string what, int act, int expv);
        fails++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    endtask

    // monitor: compares each lookup at the falling edge of its cycle
    always @(negedge clk) begin
        if (lk_req) begin
            if (exp_q.size() == 0) begin
                checks++;
                note_fail("scoreboard", "unexpected lookup", 1, 0);
            end else begin
                exp_t e;
                logic [3:0] act;
                e = exp_q.pop_front();
                act = {lk_hit, lk_miss, lk_page_fault, lk_prot_fault};
                checks++;
                if (act !== e.kind) begin
                    note_fail(e.tag, "class", int'(act), int'(e.kind));
                end else if ((e.kind == K_HIT || e.kind == K_PF || e.kind == K_PROT)
                             && lk_slot !== e.slot) begin
                    note_fail(e.tag, "slot", int'(lk_slot), int'(e.slot));
                end else if (e.kind == K_HIT && lk_ppn !== e.ppn) begin
                    note_fail(e.tag, "ppn", int'(lk_ppn), int'(e.ppn));
                end else if (e.kind == K_HIT && lk_dirty !== e.dirty) begin
                    note_fail(e.tag, "dirty", int'(lk_dirty), int'(e.dirty));
                end
            end
        end
    end

    // driver tasks: called just after a rising edge, occupy one cycle
    task automatic lookup(logic [19:0] v, logic [7:0] a, logic w, logic [3:0] k,
                          logic [15:0] p, logic [5:0] s, logic d, string tag);
        exp_t e;
        e.kind = k; e.ppn = p; e.slot = s; e.dirty = d; e.tag = tag;
        exp_q.push_back(e);
        lk_req = 1'b1; lk_write = w; lk_vpn = v; lk_asid = a;
        @(posedge clk); #1;
        lk_req = 1'b0; lk_write = 1'b0;
    endtask

    task automatic fill(logic [19:0] v, logic [7:0] a, logic [15:0] p,
                        logic pr, logic [1:0] pt);
        fill_req = 1'b1; fill_vpn = v; fill_asid = a; fill_ppn = p;
        fill_present = pr; fill_prot = pt;
        @(posedge clk); #1;
        fill_req = 1'b0;
    endtask

    task automatic do_flush_asid(logic [7:0] a);
        flush_asid_req = 1'b1; flush_asid = a;
        @(posedge clk); #1;
        flush_asid_req = 1'b0;
    endtask

    task automatic finish_run();
        @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            note_fail("scoreboard", "pending items", exp_q.size(), 0);
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            note_fail("watchdog", "run did not end", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (ready !== 1'b0) note_fail("R11", "ready in reset", int'(ready), 0);
        rst_n = 1'b1;
        // R11: ST_INIT cycle, lookup yields no class
        lookup(20'h1, 8'h1, 1'b0, K_NONE, 16'h0, 6'd0, 1'b0, "R11");
        @(negedge clk);
        checks++;
        if (ready !== 1'b1) note_fail("R11", "ready after init", int'(ready), 1);
        @(posedge clk); #1;

        // R6: free slots filled lowest first
        fill(20'h100, 8'h1, 16'h0010, 1'b1, 2'b01);
        fill(20'h101, 8'h1, 16'h0011, 1'b0, 2'b01);
        fill(20'h102, 8'h2, 16'h0012, 1'b1, 2'b10);
        lookup(20'h100, 8'h1, 1'b0, K_HIT, 16'h0010, 6'd0, 1'b0, "R1");
        lookup(20'h102, 8'h2, 1'b0, K_HIT, 16'h0012, 6'd2, 1'b0, "R6");
        lookup(20'h100, 8'h2, 1'b0, K_MISS, 16'h0, 6'd0, 1'b0, "R2");
        lookup(20'h101, 8'h1, 1'b0, K_PF, 16'h0, 6'd1, 1'b0, "R3");
        lookup(20'h999, 8'h1, 1'b0, K_MISS, 16'h0, 6'd0, 1'b0, "R3");
        // R4: write hit, dirty visible on the next lookup
        lookup(20'h100, 8'h1, 1'b1, K_HIT, 16'h0010, 6'd0, 1'b0, "R4");
        lookup(20'h100, 8'h1, 1'b0, K_HIT, 16'h0010, 6'd0, 1'b1, "R4");
        // R5: write to write-protected page
        lookup(20'h102, 8'h2, 1'b1, K_PROT, 16'h0, 6'd2, 1'b0, "R5");
        lookup(20'h102, 8'h2, 1'b0, K_HIT, 16'h0012, 6'd2, 1'b0, "R5");
        // R10: flush only process 1
        do_flush_asid(8'h1);
        lookup(20'h100, 8'h1, 1'b0, K_MISS, 16'h0, 6'd0, 1'b0, "R10");
        lookup(20'h101, 8'h1, 1'b0, K_MISS, 16'h0, 6'd0, 1'b0, "R10");
        lookup(20'h102, 8'h2, 1'b0, K_HIT, 16'h0012, 6'd2, 1'b0, "R10");
        fill(20'h200, 8'h3, 16'h0020, 1'b1, 2'b01);
        lookup(20'h200, 8'h3, 1'b0, K_HIT, 16'h0020, 6'd0, 1'b0, "R6");
        // R12: flush wins over a fill in the same cycle
        flush_asid_req = 1'b1; flush_asid = 8'h3;
        fill(20'h300, 8'h4, 16'h0030, 1'b1, 2'b01);
        flush_asid_req = 1'b0;
        lookup(20'h300, 8'h4, 1'b0, K_MISS, 16'h0, 6'd0, 1'b0, "R12");
        lookup(20'h200, 8'h3, 1'b0, K_MISS, 16'h0, 6'd0, 1'b0, "R12");
        // R9: flush all
        flush_all = 1'b1;
        @(posedge clk); #1;
        flush_all = 1'b0;
        lookup(20'h102, 8'h2, 1'b0, K_MISS, 16'h0, 6'd0, 1'b0, "R9");

        // R7 and R8: fill every slot, then replace
        for (int i = 0; i < ENTRIES; i++) begin
            fill(20'h400 + 20'(i), 8'h5, 16'h0400 + 16'(i), 1'b1, 2'b01);
        end
        for (int i = 0; i < ENTRIES - 1; i++) begin
            lookup(20'h400 + 20'(i), 8'h5, 1'b0, K_HIT, 16'h0400 + 16'(i), 6'(i), 1'b0, "R7");
        end
        fill(20'h500, 8'h5, 16'h0500, 1'b1, 2'b01);
        lookup(20'h43F, 8'h5, 1'b0, K_MISS, 16'h0, 6'd0, 1'b0, "R7");
        lookup(20'h500, 8'h5, 1'b0, K_HIT, 16'h0500, 6'd63, 1'b0, "R7");
        fill(20'h501, 8'h5, 16'h0501, 1'b1, 2'b01);
        lookup(20'h400, 8'h5, 1'b0, K_MISS, 16'h0, 6'd0, 1'b0, "R8");
        lookup(20'h501, 8'h5, 1'b0, K_HIT, 16'h0501, 6'd0, 1'b0, "R8");
        fill(20'h502, 8'h5, 16'h0502, 1'b1, 2'b01);
        lookup(20'h401, 8'h5, 1'b0, K_MISS, 16'h0, 6'd0, 1'b0, "R8");
        lookup(20'h502, 8'h5, 1'b0, K_HIT, 16'h0502, 6'd1, 1'b0, "R8");
        lookup(20'h402, 8'h5, 1'b0, K_HIT, 16'h0402, 6'd2, 1'b0, "R8");

        finish_run();
    end

endmodule